// File: doc/BRIEF.md
# Cascadable Serial-Loaded LED Channel Register

This block is the digital control core of an eight-channel LED sink driver. A serial bit stream is clocked into a chain of flip-flop stages, one position per rising clock edge. A level-sensitive hold stage passes the chain contents to the channel outputs while its load input is high. It keeps the last passed pattern while that input is low, so a new frame can be shifted in without visible flicker.

An active-low output enable gates every channel. Raising it blanks all channels without touching the held pattern, and lowering it shows that pattern again. The last stage of the chain drives a serial output, so several devices can be chained by wiring each serial output to the next device's serial input. They share clock, load and enable, and the chain behaves as one long register. The interface timing the block is built for is a shift clock of up to 20 MHz, serial data stable 10 ns before and 10 ns after each rising edge, and load pulses at least 50 ns wide.

Top module: `led_shift_latch`

## Requirements
- R1: On each rising edge of `clk` with `rst_n` high, stage k+1 takes the old value of stage k and stage 0 takes `ser_in`. The chain has `CHANNELS` stages, default 8.
- R2: Channel k shows stage k. `chan_on[0]` carries the most recently shifted bit and `chan_on[CHANNELS-1]` carries the bit shifted in `CHANNELS-1` edges earlier.
- R3: `ser_out` equals the last stage, the same bit that feeds `chan_on[CHANNELS-1]`, and changes only at a rising clock edge.
- R4: While `load_lvl` is high, the hold stage is transparent and the channels follow every shift of the chain.
- R5: While `load_lvl` is low, the hold stage keeps its value, and further shifting does not change the channels.
- R6: While `out_en_n` is 1, all channels are 0. The held pattern is not disturbed, and it reappears as soon as `out_en_n` returns to 0.
- R7: With `out_en_n` at 0, a channel is on (`chan_on[k]` = 1) when its held bit is 1 and off when it is 0.
- R8: Driving `rst_n` low clears the chain at the next rising edge and clears the hold stage while it is low, so all channels and `ser_out` read 0.
- R9: Two instances with the first one's `ser_out` wired to the second one's `ser_in` act as a 16-stage register. After 16 shifts, the first bit sent sits on the second device's top channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the chain advances on its rising edge |
| rst_n | input | 1 | Active-low reset of chain and hold stage |
| ser_in | input | 1 | Serial data into stage 0 |
| load_lvl | input | 1 | Hold stage transparent when 1, holding when 0 |
| out_en_n | input | 1 | Active-low output enable; 1 blanks all channels |
| chan_on | output | CHANNELS | Per-channel drive request, 1 = LED on |
| ser_out | output | 1 | Last chain stage, for the next device in a cascade |

## Verification
The two functions that can meet in the same cycle are a hold-stage update and output blanking. A new pattern can be passed through the hold stage while `out_en_n` is high. The bench provokes this with a vector that loads a fresh 16-bit frame into the chained pair and pulses `load_lvl` with blanking active. It first requires all 16 channels to read 0. It then lowers `out_en_n` and requires exactly the new frame to appear, not the frame held before. This shows that blanking neither stops the hold stage from loading nor corrupts what it loaded.

// File: rtl/led_sl_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the serial LED channel register.
// Assumes: consumers take the channel count from here as their default.
package led_sl_pkg;
    // Default number of chain stages and output channels
    localparam int unsigned LSL_CHANNELS = 8;
    // Smallest chain the shift module supports
    localparam int unsigned LSL_MIN_CHANNELS = 2;
endpackage

// File: rtl/led_sl_shift.sv
`timescale 1ns/1ps
// Module: led_sl_shift
// Serial-in, parallel-out chain of flip-flops. Stage 0 takes ser_in and
// every other stage takes its lower neighbour on each rising clock edge.
// Assumes: N >= 2; reset is synchronous and active low.
module led_sl_shift #(
    parameter int unsigned N = led_sl_pkg::LSL_CHANNELS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_in,
    output logic [N-1:0] stage_q
);
    localparam int unsigned TOP = N - 1;

    // Stage 0: capture the incoming serial bit
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= 1'b0;
        else        stage_q[0] <= ser_in;
    end

    // Stages 1..TOP: each one copies its lower neighbour
    for (genvar s = 1; s <= TOP; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= 1'b0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end
endmodule

// File: rtl/led_sl_hold.sv
`timescale 1ns/1ps
// Module: led_sl_hold
// Level-sensitive hold stage. It is transparent while load is high and
// keeps its last value while load is low. A low rst_n forces it to zero.
// Assumes: load pulses are clean and wide enough to settle the latches.
module led_sl_hold #(
    parameter int unsigned N = led_sl_pkg::LSL_CHANNELS
) (
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    // Transparent latch with a level clear
    always_latch begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/led_sl_gate.sv
`timescale 1ns/1ps
// Module: led_sl_gate
// Output gating. Every channel is forced off while the active-low enable
// is high; otherwise it follows its held bit.
// Assumes: purely combinational; the held data is never altered here.
module led_sl_gate #(
    parameter int unsigned N = led_sl_pkg::LSL_CHANNELS
) (
    input  logic         en_n,
    input  logic [N-1:0] held,
    output logic [N-1:0] chan_on
);
    // One AND gate per channel
    for (genvar k = 0; k < N; k++) begin : g_chan
        assign chan_on[k] = held[k] & ~en_n;
    end
endmodule

// File: rtl/led_shift_latch.sv
`timescale 1ns/1ps
// Module: led_shift_latch (top)
// Control logic of a cascadable LED sink driver: a serial chain, a
// level-sensitive hold stage and active-low output gating. ser_out is the
// last chain stage, so it changes only on a rising clock edge.
// Assumes: CHANNELS >= 2; devices in a cascade share clk, load_lvl, out_en_n.
module led_shift_latch #(
    parameter int unsigned CHANNELS = led_sl_pkg::LSL_CHANNELS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_in,
    input  logic                load_lvl,
    input  logic                out_en_n,
    output logic [CHANNELS-1:0] chan_on,
    output logic                ser_out
);
    localparam int unsigned LAST = CHANNELS - 1;

    logic [CHANNELS-1:0] stage_q;
    logic [CHANNELS-1:0] held_q;

    // Serial chain
    led_sl_shift #(.N(CHANNELS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_in  (ser_in),
        .stage_q (stage_q)
    );

    // Level-sensitive hold stage
    led_sl_hold #(.N(CHANNELS)) u_hold (
        .rst_n (rst_n),
        .load  (load_lvl),
        .d     (stage_q),
        .q     (held_q)
    );

    // Output blanking
    led_sl_gate #(.N(CHANNELS)) u_gate (
        .en_n    (out_en_n),
        .held    (held_q),
        .chan_on (chan_on)
    );

    // Cascade tap from the last flip-flop
    assign ser_out = stage_q[LAST];
endmodule

// File: rtl/led_shift_latch_chk.sv
`timescale 1ns/1ps
// Module: led_shift_latch_chk
// Assertion checker bound to led_shift_latch.
// Assumes: properties are sampled at the rising clock edge.
module led_shift_latch_chk #(
    parameter int unsigned CHANNELS = led_sl_pkg::LSL_CHANNELS
) (
    input logic                clk,
    input logic                rst_n,
    input logic                load_lvl,
    input logic                out_en_n,
    input logic [CHANNELS-1:0] chan_on,
    input logic                ser_out,
    input logic [CHANNELS-1:0] stage_q
);
    // R6
    blank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> (chan_on == '0));

    // R4
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_lvl && !out_en_n) |-> (chan_on == stage_q));

    // R3
    tail_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_lvl && !out_en_n) |-> (chan_on[CHANNELS-1] == ser_out));

    // R1
    stage_march_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stage_q[CHANNELS-1:1] == $past(stage_q[CHANNELS-2:0])));

    // R8
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ((stage_q == '0) && (chan_on == '0) && !ser_out));
endmodule

bind led_shift_latch led_shift_latch_chk #(.CHANNELS(CHANNELS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_lvl (load_lvl),
    .out_en_n (out_en_n),
    .chan_on  (chan_on),
    .ser_out  (ser_out),
    .stage_q  (stage_q)
);

// File: tb/led_shift_latch_bench.sv
`timescale 1ns/1ps
module led_shift_latch_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       load_lvl = 1'b0;
    logic       out_en_n = 1'b0;
    logic [7:0] head_chan, tail_chan;
    logic       head_sout, tail_sout;
    logic [15:0] both;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;
    assign both = {tail_chan, head_chan};

    led_shift_latch u_led_shift_latch (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .load_lvl(load_lvl),
        .out_en_n(out_en_n), .chan_on(head_chan), .ser_out(head_sout)
    );
    led_shift_latch u_led_shift_latch_tail (
        .clk(clk), .rst_n(rst_n), .ser_in(head_sout), .load_lvl(load_lvl),
        .out_en_n(out_en_n), .chan_on(tail_chan), .ser_out(tail_sout)
    );

    // {out_en_n, frame}; frame bit 15 is sent first
    localparam logic [16:0] VEC [6] = '{
        {1'b0, 16'hA5C3}, {1'b0, 16'hFFFF}, {1'b1, 16'h0F0F},
        {1'b0, 16'h0001}, {1'b0, 16'h8000}, {1'b0, 16'h0000}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic shift16(input logic [15:0] frame);
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk);
            ser_in = frame[i];
        end
        @(negedge clk);
    endtask

    task automatic pulse_load();
        #2 load_lvl = 1'b1;
        #4 load_lvl = 1'b0;
        #1;
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] prev;
        logic [15:0] frame;
        logic        blank;
        repeat (3) @(negedge clk);
        chk("R8 reset channels", both, 16'h0000);
        chk("R8 reset serial outs", {14'd0, tail_sout, head_sout}, 16'h0000);
        rst_n = 1'b1;
        prev = 16'h0000;

        // Vector walk
        for (int v = 0; v < 6; v++) begin
            blank = VEC[v][16];
            frame = VEC[v][15:0];
            out_en_n = blank;
            shift16(frame);
            chk("R5 hold while shifting", both, blank ? 16'h0000 : prev);
            chk("R3 serial outs", {14'd0, tail_sout, head_sout},
                {14'd0, frame[15], frame[7]});
            pulse_load();
            chk(blank ? "R6 blanked load" : "R9 R2 R7 frame shown", both,
                blank ? 16'h0000 : frame);
            if (blank) begin
                out_en_n = 1'b0;
                #1 chk("R6 unblank restores new frame", both, frame);
            end
            prev = frame;
        end

        // Enable toggle on a held pattern
        out_en_n = 1'b1;
        #1 chk("R6 blank", both, 16'h0000);
        out_en_n = 1'b0;
        #1 chk("R6 restore", both, prev);

        // Transparent hold stage follows every shift (chain is all zero)
        @(negedge clk);
        load_lvl = 1'b1;
        ser_in = 1'b1;
        @(negedge clk);
        chk("R4 R1 newest on chan0", {15'd0, head_chan[0]}, 16'h0001);
        ser_in = 1'b0;
        @(negedge clk);
        chk("R4 R2 shifted up", {8'd0, head_chan}, 16'h0002);
        ser_in = 1'b1;
        @(negedge clk);
        chk("R4 R1 three shifts", {13'd0, head_chan[2:0]}, 16'h0005);
        load_lvl = 1'b0;
        ser_in = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 held after load falls", {13'd0, head_chan[2:0]}, 16'h0005);

        // Reset clears held ones
        shift16(16'hFFFF);
        pulse_load();
        chk("R7 all on", both, 16'hFFFF);
        rst_n = 1'b0;
        #1 chk("R8 hold cleared by reset", both, 16'h0000);
        @(negedge clk);
        chk("R8 serial outs cleared", {14'd0, tail_sout, head_sout}, 16'h0000);
        rst_n = 1'b1;
        ser_in = 1'b0;
        pulse_load();
        chk("R8 chain cleared", both, 16'h0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule